// File: doc/BRIEF.md
# Multiplierless 5/3 Wavelet Filter Pair

This block performs one level of the one-dimensional reversible 5/3 wavelet analysis on pixels that arrive one at a time. Accepted pixels enter a short shift register. Two outputs are formed from its taps, a smoothed (low-pass) value and a detail (high-pass) value. The arithmetic uses only additions, negations and fixed power-of-two shifts. There is no multiplier anywhere in the datapath.

The block runs on a single clock. An internal enable toggles on every cycle, which halves the rate at which samples can be taken. This enable is also driven out so that logic upstream can pace its pixels to it. A pixel is taken only in a cycle where the enable is high and the pixel strobe is asserted. The two results are registered. A valid flag reports when the shift register holds a full window of real samples.

Top module: `wav53_pair`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `lo_out` = 0, `hi_out` = 0, `out_vld` = 0 and `half_en` = 0, and the tap register is cleared to zero.
- R2: Outside reset, `half_en` inverts on every clock edge. It is 1 after the first edge at which `rst` is low.
- R3: A pixel is accepted only at an edge where `pix_vld` = 1 and `half_en` = 1. A pixel offered while `half_en` = 0 is ignored and leaves no trace in any later result.
- R4: Name the accepted samples s0 (newest) to s4 (oldest). `lo_out` equals floor((−s0 + 2·s1 + 6·s2 + 2·s3 − s4) / 8) as a two's-complement 10-bit value.
- R5: `hi_out` equals floor((−s1 + 2·s2 − s3) / 4) as a two's-complement 10-bit value.
- R6: `out_vld` goes to 1 one edge after the fifth sample accepted since reset. It then stays at 1 until reset.
- R7: `lo_out` and `hi_out` update one edge after each acceptance. In every other cycle they hold their value.
- R8: No result wraps for any 8-bit inputs. `lo_out` reaches 318 for the window 0,255,255,255,0 and −64 for 255,0,0,0,255. `hi_out` reaches 127 when s1=s3=0 and s2=255. It reaches −128 when s1=s3=255 and s2=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 8 | Unsigned pixel value |
| pix_vld | input | 1 | Pixel strobe; the pixel is taken only when `half_en` is also high |
| lo_out | output | 10 | Signed low-pass result, registered |
| hi_out | output | 10 | Signed high-pass result, registered |
| out_vld | output | 1 | High once a full window of accepted samples has been seen |
| half_en | output | 1 | Half-rate enable, toggling every clock |

## Verification
Two events coincide on the edge that follows the fifth acceptance. The valid flag rises, and the output registers load the first result computed from a full window. The bench schedules each expected result, and the cycle at which `out_vld` must turn high, from its own count of samples accepted through the `half_en` port. It then checks the flag and the data in the same cycle. Every pixel is preceded by a junk value offered with the strobe high during the dead phase, so any leak through the rate gate corrupts a later result. A reset in the middle of a run, followed by only four samples, confirms that the flag rises again only after a fresh five samples.

// File: rtl/wav53_pkg.sv
package wav53_pkg;
  localparam int TAP_COUNT   = 5;
  localparam int FILL_NEEDED = 5;
  localparam int LO_SHIFT    = 3;
  localparam int HI_SHIFT    = 2;
  localparam int GUARD_BITS  = 5;
endpackage

// File: rtl/wav53_rate.sv
module wav53_rate (
  input  logic clk,
  input  logic rst,
  output logic phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end
endmodule

// File: rtl/wav53_tapline.sv
module wav53_tapline #(
  parameter int PIX_W = 8,
  parameter int TAPS  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    shift,
  input  logic [PIX_W-1:0]        din,
  output logic [TAPS*PIX_W-1:0]   taps
);
  logic [PIX_W-1:0] stage [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)        stage[0] <= '0;
        else if (shift) stage[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)        stage[g] <= '0;
        else if (shift) stage[g] <= stage[g-1];
      end
    end
    assign taps[g*PIX_W +: PIX_W] = stage[g];
  end
endmodule

// File: rtl/wav53_lowpass.sv
module wav53_lowpass
  import wav53_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SUM_W = 13,
  parameter int OUT_W = 10
) (
  input  logic [PIX_W-1:0]        x0,
  input  logic [PIX_W-1:0]        x1,
  input  logic [PIX_W-1:0]        x2,
  input  logic [PIX_W-1:0]        x3,
  input  logic [PIX_W-1:0]        x4,
  output logic signed [OUT_W-1:0] y
);
  localparam int PAD = SUM_W - PIX_W;

  logic signed [SUM_W-1:0] e0, e1, e2, e3, e4, acc;

  assign e0 = $signed({{PAD{1'b0}}, x0});
  assign e1 = $signed({{PAD{1'b0}}, x1});
  assign e2 = $signed({{PAD{1'b0}}, x2});
  assign e3 = $signed({{PAD{1'b0}}, x3});
  assign e4 = $signed({{PAD{1'b0}}, x4});

  // centre tap weight 6 = 4 + 2, side taps weight 2, outer taps weight -1
  always_comb begin
    acc = (e2 <<< 2) + (e2 <<< 1) + (e1 <<< 1) + (e3 <<< 1) - e0 - e4;
  end

  assign y = OUT_W'(acc >>> LO_SHIFT);
endmodule

// File: rtl/wav53_highpass.sv
module wav53_highpass
  import wav53_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SUM_W = 13,
  parameter int OUT_W = 10
) (
  input  logic [PIX_W-1:0]        x1,
  input  logic [PIX_W-1:0]        x2,
  input  logic [PIX_W-1:0]        x3,
  output logic signed [OUT_W-1:0] y
);
  localparam int PAD = SUM_W - PIX_W;

  logic signed [SUM_W-1:0] e1, e2, e3, acc;

  assign e1 = $signed({{PAD{1'b0}}, x1});
  assign e2 = $signed({{PAD{1'b0}}, x2});
  assign e3 = $signed({{PAD{1'b0}}, x3});

  always_comb begin
    acc = (e2 <<< 1) - e1 - e3;
  end

  assign y = OUT_W'(acc >>> HI_SHIFT);
endmodule

// File: rtl/wav53_pair.sv
module wav53_pair
  import wav53_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PIX_W-1:0]        pix_in,
  input  logic                    pix_vld,
  output logic signed [PIX_W+1:0] lo_out,
  output logic signed [PIX_W+1:0] hi_out,
  output logic                    out_vld,
  output logic                    half_en
);
  localparam int SUM_W = PIX_W + GUARD_BITS;
  localparam int OUT_W = PIX_W + 2;
  localparam int CNT_W = $clog2(FILL_NEEDED + 1);
  localparam logic [CNT_W-1:0] FILL_TOP = CNT_W'(FILL_NEEDED);

  logic                       phase;
  logic                       take;
  logic [TAP_COUNT*PIX_W-1:0] taps;
  logic [PIX_W-1:0]           s0, s1, s2, s3, s4;
  logic signed [OUT_W-1:0]    lo_c, hi_c;
  logic [CNT_W-1:0]           fill_cnt;

  wav53_rate u_rate (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  assign take    = phase & pix_vld;
  assign half_en = phase;

  wav53_tapline #(.PIX_W(PIX_W), .TAPS(TAP_COUNT)) u_taps (
    .clk   (clk),
    .rst   (rst),
    .shift (take),
    .din   (pix_in),
    .taps  (taps)
  );

  assign s0 = taps[0*PIX_W +: PIX_W];
  assign s1 = taps[1*PIX_W +: PIX_W];
  assign s2 = taps[2*PIX_W +: PIX_W];
  assign s3 = taps[3*PIX_W +: PIX_W];
  assign s4 = taps[4*PIX_W +: PIX_W];

  wav53_lowpass #(.PIX_W(PIX_W), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_lo (
    .x0 (s0),
    .x1 (s1),
    .x2 (s2),
    .x3 (s3),
    .x4 (s4),
    .y  (lo_c)
  );

  wav53_highpass #(.PIX_W(PIX_W), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_hi (
    .x1 (s1),
    .x2 (s2),
    .x3 (s3),
    .y  (hi_c)
  );

  // saturating count of accepted samples since reset
  always_ff @(posedge clk) begin
    if (rst)                             fill_cnt <= '0;
    else if (take && fill_cnt != FILL_TOP) fill_cnt <= fill_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_out  <= '0;
      hi_out  <= '0;
      out_vld <= 1'b0;
    end else begin
      lo_out  <= lo_c;
      hi_out  <= hi_c;
      out_vld <= (fill_cnt == FILL_TOP);
    end
  end
endmodule

// File: rtl/wav53_pair_chk.sv
module wav53_pair_chk #(
  parameter int PIX_W = 8,
  parameter int OUT_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    pix_vld,
  input logic                    half_en,
  input logic signed [OUT_W-1:0] lo_out,
  input logic signed [OUT_W-1:0] hi_out,
  input logic                    out_vld
);
  localparam int PMAX   = (2 ** PIX_W) - 1;
  localparam int LO_MAX = (PMAX * 10) / 8;
  localparam int LO_MIN = -((PMAX * 2 + 7) / 8);
  localparam int HI_MAX = (PMAX * 2) / 4;
  localparam int HI_MIN = -((PMAX * 2 + 3) / 4);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (lo_out == '0 && hi_out == '0 && !out_vld && !half_en));

  p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (half_en != $past(half_en)));

  p_lo_range_r8: assert property (@(posedge clk) disable iff (rst)
    (lo_out >= LO_MIN && lo_out <= LO_MAX));

  p_hi_range_r8: assert property (@(posedge clk) disable iff (rst)
    (hi_out >= HI_MIN && hi_out <= HI_MAX));

  p_vld_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> out_vld);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(half_en && pix_vld) |=> ##1 ($stable(lo_out) && $stable(hi_out)));
endmodule

bind wav53_pair wav53_pair_chk #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pix_vld (pix_vld),
  .half_en (half_en),
  .lo_out  (lo_out),
  .hi_out  (hi_out),
  .out_vld (out_vld)
);

// File: tb/wav53_pair_test.sv
module wav53_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int NEVER      = 1 << 30;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        pix_in = '0;
  logic              pix_vld = 1'b0;
  logic signed [9:0] lo_out, hi_out;
  logic              out_vld, half_en;

  wav53_pair uut (
    .clk     (clk),
    .rst     (rst),
    .pix_in  (pix_in),
    .pix_vld (pix_vld),
    .lo_out  (lo_out),
    .hi_out  (hi_out),
    .out_vld (out_vld),
    .half_en (half_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int due; int lo; int hi; } exp_t;
  exp_t sbq[$];

  int  cyc = 0;
  int  checks = 0;
  int  fails = 0;
  int  hist[5];
  int  acc_cnt = 0;
  int  vld_due = NEVER;
  int  last_lo = 0, last_hi = 0;
  bit  have_last = 0;
  bit  done = 0;
  bit  prev_ok = 0;
  logic prev_half = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int floor_shift(int v, int sh);
    return v >>> sh;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 5; i++) hist[i] = 0;
    acc_cnt = 0;
    vld_due = NEVER;
    have_last = 0;
    last_lo = 0;
    last_hi = 0;
    sbq.delete();
  endtask

  // scoreboard producer: runs just after the driving negedge, before the accepting edge
  task automatic model_accept(int p);
    exp_t e;
    for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = p;
    acc_cnt++;
    if (acc_cnt >= 5) begin
      e.due = cyc + 2;
      e.lo  = floor_shift(-hist[0] + 2*hist[1] + 6*hist[2] + 2*hist[3] - hist[4], 3); // R4
      e.hi  = floor_shift(-hist[1] + 2*hist[2] - hist[3], 2);                         // R5
      sbq.push_back(e);
      if (acc_cnt == 5) vld_due = cyc + 2;                                              // R6
    end
  endtask

  // offers a junk pixel during the dead phase (R3), then the real one
  task automatic send(int p);
    @(negedge clk);
    if (!half_en) begin
      pix_vld = 1'b1;
      pix_in  = 8'(~p);
      @(negedge clk);
    end
    pix_vld = 1'b1;
    pix_in  = 8'(p);
    #1;
    model_accept(p);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      pix_vld = 1'b0;
      pix_in  = 8'($urandom_range(0, 255));
    end
  endtask

  task automatic expect_ports(int lo, int hi, string req);
    @(negedge clk);
    #3;
    chk(lo_out == lo, req, int'(lo_out), lo);
    chk(hi_out == hi, req, int'(hi_out), hi);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pix_vld = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(lo_out == 0, "R1 lo", int'(lo_out), 0);
    chk(hi_out == 0, "R1 hi", int'(hi_out), 0);
    chk(out_vld == 1'b0, "R1 vld", int'(out_vld), 0);
    chk(half_en == 1'b0, "R1 half_en", int'(half_en), 0);
    model_clear();
    @(negedge clk);
    rst = 1'b0;
  endtask

  // scoreboard consumer
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst) begin
        prev_ok = 0;
      end else begin
        if (sbq.size() > 0 && sbq[0].due == cyc) begin
          exp_t e;
          e = sbq.pop_front();
          chk(lo_out == e.lo, "R4 lo_out", int'(lo_out), e.lo);
          chk(hi_out == e.hi, "R5 hi_out", int'(hi_out), e.hi);
          last_lo = e.lo;
          last_hi = e.hi;
          have_last = 1;
        end else if (have_last) begin
          chk(lo_out == last_lo && hi_out == last_hi, "R7 hold", int'(lo_out), last_lo);
        end
        chk(out_vld == (cyc >= vld_due), "R6 out_vld", int'(out_vld), int'(cyc >= vld_due));
        if (prev_ok) chk(half_en != prev_half, "R2 toggle", int'(half_en), int'(!prev_half));
        prev_half = half_en;
        prev_ok = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    @(negedge clk);
    #1;
    chk(half_en == 1'b1, "R2 first phase", int'(half_en), 1);

    // ramp fill
    for (int i = 0; i < 12; i++) send(i * 20);
    idle(4);

    // extremes, oldest first (R8)
    send(0); send(255); send(255); send(255); send(0);
    idle(3);
    expect_ports(318, 0, "R8 lo max");
    send(255); send(0); send(0); send(0); send(255);
    idle(3);
    expect_ports(-64, 0, "R8 lo min");
    send(0); send(0); send(255); send(0); send(0);
    idle(3);
    expect_ports(191, 127, "R8 hi max");
    send(0); send(255); send(0); send(255); send(0);
    idle(3);
    expect_ports(127, -128, "R8 hi min");
    send(255); send(255); send(255); send(255); send(255);
    idle(3);
    expect_ports(255, 0, "R4 flat");

    // random pixels with gaps
    for (int i = 0; i < 300; i++) begin
      send($urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    // reset mid-run: valid must need five fresh samples (R6, R1)
    do_reset();
    for (int i = 0; i < 4; i++) send(200 - i * 30);
    idle(4);
    chk(out_vld == 1'b0, "R6 four samples", int'(out_vld), 0);
    send(77);
    idle(3);
    chk(out_vld == 1'b1, "R6 fifth sample", int'(out_vld), 1);
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule